// File: doc/BRIEF.md
# Round-Robin Tick-Scheduled DMA Engine

This block is a memory-to-memory copy engine with several independent channels. Each channel holds a source address, a destination address, a remaining byte count, a run flag and a fault-injection counter. A one-cycle service tick drives the engine. Each accepted tick inspects exactly one channel, and the channel pointer rotates through all channels in order. When the inspected channel is running, the engine does one of three things:

- it copies a bounded burst;
- it finishes the transfer and raises a completion flag;
- it raises an error flag when its fault counter expires.

A long transfer is therefore spread over many visits, and each visit moves at most one burst.

Software programs the channels through a flat word-indexed register port. The bursts run as alternating 32-bit reads and writes on a valid/ready memory master port. Per-channel completion and error flags are write-one-to-clear, and they are ORed onto a single interrupt line.

Top module: `dma_rr_engine`

Register word indices, for channel c:

| Index | Register |
|---|---|
| `4c` | source address |
| `4c+1` | destination address |
| `4c+2` | remaining count |
| `4c+3` | control, bit 31 = run |
| `4N` | completion flags, bit c |
| `4N+1` | error flags, bit c |
| `4N+2+c` | fault counter |

## Requirements
- R1: Each accepted tick services exactly one channel. The pointer starts at channel 0 after reset and advances by one after every service, wrapping from NUM_CH-1 to 0. A channel whose run bit is clear still uses up its slot.
- R2: Servicing a running channel with a nonzero count copies min(count, BURST_BYTES) bytes as 32-bit words from source to destination. It then adds that length to both addresses and subtracts it from the count.
- R3: Servicing a running channel whose count is zero clears its run bit, sets its bit in the completion flags and raises the interrupt. No memory access takes place.
- R4: A nonzero fault counter is decremented on each service of a running channel. The service in which the counter goes from 1 to 0 clears run, sets the error flag and raises the interrupt, and moves no data and leaves the count unchanged. A channel that is not running leaves its counter untouched.
- R5: A control write with bit 31 set is ignored unless the channel's count is a multiple of 4 and at most MAX_COUNT (0x1FFF).
- R6: A control write with bit 31 clear stops the channel. It clears only the run bit and raises no flag.
- R7: Writing 1 to a completion-flag or error-flag bit clears that bit, and writing 0 leaves it unchanged. The interrupt output is high exactly while any flag bit is set.
- R8: While a burst is in progress, `busy` is high and ticks are ignored. The pointer moves on only when the burst's last write completes.
- R9: Writes to the source, destination or count register of a channel whose run bit is set are ignored.
- R10: After reset, every register reads zero, and `irq`, `busy` and `memReq` are low.
- R11: A memory request that is not yet accepted keeps its request, direction, address and write data unchanged until `memReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Service tick; accepted only while not busy |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the word |
| memWData | output | 32 | Write data |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRData | input | 32 | Read data, valid together with memReady on a read |
| busy | output | 1 | A burst is in progress |
| irq | output | 1 | OR of all completion and error flags |

## Verification
The bench builds the engine with four channels and BURST_BYTES set to 16. A transfer of up to 64 bytes therefore needs several visits, and the partial-burst and exact-burst cases come up in a sweep of a few dozen transfers over every channel. With the count limit left at 0x1FFF, the start-validation boundary is tested at its real value. The fault counter, the flag clearing, the tick-ignored-while-busy rule and the memory stalls are covered by targeted sequences. The expected tick totals and memory contents come from arithmetic on the channel pointer and the burst size.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  localparam int REG_W   = 32;
  localparam int RUN_BIT = 31;

  typedef struct packed {
    logic clrRun;
    logic setDone;
    logic setErr;
    logic decFail;
    logic advance;
  } svc_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } svc_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_rr_pkg::*;
#(
  parameter int            NUM_CH    = 4,
  parameter int            ADDR_W    = 32,
  parameter int            FAIL_W    = 8,
  parameter logic [31:0]   MAX_COUNT = 32'h1FFF,
  parameter int            REG_AW    = 5,
  parameter int            CH_W      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [CH_W-1:0]      selCh,
  input  svc_strobe_t          stb,
  input  logic [REG_W-1:0]     advBytes,
  output logic [NUM_CH-1:0]    runVec,
  output logic [ADDR_W-1:0]    selSrc,
  output logic [ADDR_W-1:0]    selDst,
  output logic [REG_W-1:0]     selCnt,
  output logic [FAIL_W-1:0]    selFail,
  output logic                 irq
);
  localparam int DONE_IDX  = NUM_CH * 4;
  localparam int ERR_IDX   = DONE_IDX + 1;
  localparam int FAIL_BASE = DONE_IDX + 2;

  logic [ADDR_W-1:0] srcQ  [NUM_CH];
  logic [ADDR_W-1:0] dstQ  [NUM_CH];
  logic [REG_W-1:0]  cntQ  [NUM_CH];
  logic [FAIL_W-1:0] failQ [NUM_CH];
  logic [NUM_CH-1:0] runQ, doneQ, errQ;

  function automatic logic wrHit(input int idx);
    return regWrEn && (regAddr == REG_AW'(idx));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        srcQ[i]  <= '0;
        dstQ[i]  <= '0;
        cntQ[i]  <= '0;
        failQ[i] <= '0;
      end
      runQ  <= '0;
      doneQ <= '0;
      errQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        // host side: address and count frozen while the channel runs
        if (!runQ[i] && wrHit(i*4 + 0)) srcQ[i] <= regWrData[ADDR_W-1:0];
        if (!runQ[i] && wrHit(i*4 + 1)) dstQ[i] <= regWrData[ADDR_W-1:0];
        if (!runQ[i] && wrHit(i*4 + 2)) cntQ[i] <= regWrData;
        if (wrHit(i*4 + 3)) begin
          if (!regWrData[RUN_BIT])
            runQ[i] <= 1'b0;
          else if ((cntQ[i][1:0] == 2'b00) && (cntQ[i] <= MAX_COUNT))
            runQ[i] <= 1'b1;
        end
        if (wrHit(FAIL_BASE + i))
          failQ[i] <= regWrData[FAIL_W-1:0];
        else if ((selCh == CH_W'(i)) && stb.decFail)
          failQ[i] <= failQ[i] - 1'b1;
        if (wrHit(DONE_IDX) && regWrData[i]) doneQ[i] <= 1'b0;
        if (wrHit(ERR_IDX)  && regWrData[i]) errQ[i]  <= 1'b0;
        // service side wins over a host write in the same cycle
        if (selCh == CH_W'(i)) begin
          if (stb.clrRun)  runQ[i]  <= 1'b0;
          if (stb.setDone) doneQ[i] <= 1'b1;
          if (stb.setErr)  errQ[i]  <= 1'b1;
          if (stb.advance) begin
            srcQ[i] <= srcQ[i] + ADDR_W'(advBytes);
            dstQ[i] <= dstQ[i] + ADDR_W'(advBytes);
            cntQ[i] <= cntQ[i] - advBytes;
          end
        end
      end
    end
  end

  assign runVec  = runQ;
  assign selSrc  = srcQ[selCh];
  assign selDst  = dstQ[selCh];
  assign selCnt  = cntQ[selCh];
  assign selFail = failQ[selCh];
  assign irq     = (|doneQ) | (|errQ);

  always_comb begin
    logic [CH_W-1:0] rdCh;
    regRdData = '0;
    rdCh      = CH_W'(regAddr >> 2);
    if (regAddr < REG_AW'(DONE_IDX)) begin
      case (regAddr[1:0])
        2'd0:    regRdData = REG_W'(srcQ[rdCh]);
        2'd1:    regRdData = REG_W'(dstQ[rdCh]);
        2'd2:    regRdData = cntQ[rdCh];
        default: regRdData = {runQ[rdCh], {(REG_W-1){1'b0}}};
      endcase
    end else if (regAddr == REG_AW'(DONE_IDX)) begin
      regRdData = REG_W'(doneQ);
    end else if (regAddr == REG_AW'(ERR_IDX)) begin
      regRdData = REG_W'(errQ);
    end else if (regAddr < REG_AW'(FAIL_BASE + NUM_CH)) begin
      regRdData = REG_W'(failQ[CH_W'(regAddr - REG_AW'(FAIL_BASE))]);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r3_done_stops_run: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneQ[g]) |-> !runQ[g]);
    a_r4_err_stops_run: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errQ[g]) |-> !runQ[g]);
    a_r5_start_valid_count: assert property (@(posedge clk) disable iff (!rstN)
      $rose(runQ[g]) |-> (cntQ[g][1:0] == 2'b00) && (cntQ[g] <= MAX_COUNT));
    a_r9_frozen_while_running: assert property (@(posedge clk) disable iff (!rstN)
      runQ[g] && !((selCh == CH_W'(g)) && stb.advance)
      |=> $stable(srcQ[g]) && $stable(dstQ[g]) && $stable(cntQ[g]));
  end
endmodule

// File: rtl/dma_svc_ctrl.sv
module dma_svc_ctrl
  import dma_rr_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 32,
  parameter int FAIL_W      = 8,
  parameter int BURST_BYTES = 2048,
  parameter int CH_W        = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic [NUM_CH-1:0]    runVec,
  input  logic [ADDR_W-1:0]    selSrc,
  input  logic [ADDR_W-1:0]    selDst,
  input  logic [REG_W-1:0]     selCnt,
  input  logic [FAIL_W-1:0]    selFail,
  output logic [CH_W-1:0]      selCh,
  output svc_strobe_t          stb,
  output logic [REG_W-1:0]     advBytes,
  output logic                 busy,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [REG_W-1:0]     memWData,
  input  logic                 memReady,
  input  logic [REG_W-1:0]     memRData
);
  localparam logic [REG_W-1:0] WORD_B  = REG_W'(4);
  localparam logic [REG_W-1:0] BURST_B = REG_W'(BURST_BYTES);
  localparam logic [CH_W-1:0]  LAST_CH = CH_W'(NUM_CH - 1);

  svc_state_e        stQ;
  logic [CH_W-1:0]   ptrQ;
  logic [REG_W-1:0]  lenQ, offQ, holdQ;

  logic idleTick, chRun, failLast, startBurst, lastBeat;
  logic [CH_W-1:0]  ptrNext;
  logic [REG_W-1:0] burstLen;

  assign idleTick   = (stQ == ST_IDLE) && tick;
  assign chRun      = runVec[ptrQ];
  assign failLast   = (selFail == FAIL_W'(1));
  assign burstLen   = (selCnt > BURST_B) ? BURST_B : selCnt;
  assign startBurst = idleTick && chRun && !failLast && (selCnt != '0);
  assign lastBeat   = (stQ == ST_WRITE) && memReady && (offQ + WORD_B == lenQ);
  assign ptrNext    = (ptrQ == LAST_CH) ? '0 : ptrQ + 1'b1;

  always_comb begin
    stb = '0;
    if (idleTick && chRun) begin
      stb.decFail = (selFail != '0);
      if (failLast) begin
        stb.clrRun = 1'b1;
        stb.setErr = 1'b1;
      end else if (selCnt == '0) begin
        stb.clrRun  = 1'b1;
        stb.setDone = 1'b1;
      end
    end
    stb.advance = lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      ptrQ  <= '0;
      lenQ  <= '0;
      offQ  <= '0;
      holdQ <= '0;
    end else begin
      case (stQ)
        ST_IDLE: if (idleTick) begin
          if (startBurst) begin
            stQ  <= ST_READ;
            lenQ <= burstLen;
            offQ <= '0;
          end else begin
            ptrQ <= ptrNext;
          end
        end
        ST_READ: if (memReady) begin
          holdQ <= memRData;
          stQ   <= ST_WRITE;
        end
        ST_WRITE: if (memReady) begin
          if (offQ + WORD_B == lenQ) begin
            stQ  <= ST_IDLE;
            ptrQ <= ptrNext;
          end else begin
            offQ <= offQ + WORD_B;
            stQ  <= ST_READ;
          end
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  assign selCh    = ptrQ;
  assign advBytes = lenQ;
  assign busy     = (stQ != ST_IDLE);
  assign memReq   = (stQ != ST_IDLE);
  assign memWe    = (stQ == ST_WRITE);
  assign memAddr  = ((stQ == ST_WRITE) ? selDst : selSrc) + ADDR_W'(offQ);
  assign memWData = holdQ;

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memWe) && $stable(memAddr) && $stable(memWData));
  a_r8_ptr_frozen_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    (stQ != ST_IDLE) && !lastBeat |=> $stable(ptrQ));
  a_r1_ptr_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptrQ) |-> ptrQ == (($past(ptrQ) == LAST_CH) ? '0 : $past(ptrQ) + 1'b1));
  a_r2_burst_len_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_READ) |-> (lenQ != '0) && (lenQ <= BURST_B) && (lenQ[1:0] == 2'b00));
endmodule

// File: rtl/dma_rr_engine.sv
module dma_rr_engine
  import dma_rr_pkg::*;
#(
  parameter int          NUM_CH      = 4,
  parameter int          ADDR_W      = 32,
  parameter int          FAIL_W      = 8,
  parameter int          BURST_BYTES = 2048,
  parameter logic [31:0] MAX_COUNT   = 32'h1FFF,
  parameter int          REG_AW      = $clog2(NUM_CH * 5 + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWData,
  input  logic               memReady,
  input  logic [31:0]        memRData,
  output logic               busy,
  output logic               irq
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0]   selCh;
  svc_strobe_t       stb;
  logic [REG_W-1:0]  advBytes, selCnt;
  logic [NUM_CH-1:0] runVec;
  logic [ADDR_W-1:0] selSrc, selDst;
  logic [FAIL_W-1:0] selFail;

  dma_chan_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FAIL_W(FAIL_W),
    .MAX_COUNT(MAX_COUNT), .REG_AW(REG_AW), .CH_W(CH_W)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .selCh(selCh), .stb(stb), .advBytes(advBytes),
    .runVec(runVec), .selSrc(selSrc), .selDst(selDst), .selCnt(selCnt), .selFail(selFail),
    .irq(irq)
  );

  dma_svc_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FAIL_W(FAIL_W),
    .BURST_BYTES(BURST_BYTES), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .runVec(runVec), .selSrc(selSrc), .selDst(selDst), .selCnt(selCnt), .selFail(selFail),
    .selCh(selCh), .stb(stb), .advBytes(advBytes), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memReady(memReady), .memRData(memRData)
  );
endmodule

// File: tb/dma_rr_engine_tb.sv
`timescale 1ns/1ps
module dma_rr_engine_tb;
  localparam int NCH   = 4;
  localparam int BURST = 16;
  localparam int DONE_R = NCH * 4;
  localparam int ERR_R  = DONE_R + 1;
  localparam int FAIL_R = DONE_R + 2;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic memReq, memWe, memReady, busy, irq;
  logic [31:0] memAddr, memWData, memRData;

  logic [31:0] mem [0:1023];
  logic        tbWe = 1'b0;
  logic [9:0]  tbIdx = '0;
  logic [31:0] tbData = '0;
  logic [1:0]  stallCnt = '0;
  logic        stallMode = 1'b0;

  int nChecks = 0, nFails = 0, expPtr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_rr_engine #(.NUM_CH(NCH), .BURST_BYTES(BURST)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memReady(memReady), .memRData(memRData),
    .busy(busy), .irq(irq)
  );

  assign memReady = stallMode ? (stallCnt != 2'd0) : 1'b1;
  assign memRData = mem[memAddr[11:2]];

  always @(posedge clk) begin
    stallCnt <= stallCnt + 2'd1;
    if (tbWe) mem[tbIdx] <= tbData;
    else if (memReq && memReady && memWe) mem[memAddr[11:2]] <= memWData;
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h5A000000 + 32'(i) * 32'h00010101;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk); tbWe = 1'b1; tbIdx = 10'(idx); tbData = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = 5'(a); regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); regAddr = 5'(a); #1 d = regRdData;
  endtask

  task automatic tickOnce();
    @(negedge clk); while (busy) @(negedge clk);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    while (busy) @(negedge clk);
    expPtr = (expPtr + 1) % NCH;
  endtask

  task automatic ticks(input int n);
    for (int t = 0; t < n; t++) tickOnce();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    // R10 reset state
    for (int a = 0; a < FAIL_R + NCH; a++) begin
      rd(a, v); chk("R10", $sformatf("reg %0d after reset", a), v, 32'h0);
    end
    chk("R10", "irq after reset", {31'b0, irq}, 32'h0);
    chk("R10", "busy after reset", {31'b0, busy}, 32'h0);
    chk("R10", "memReq after reset", {31'b0, memReq}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // Sweep: every channel, several counts (R1 R2 R3 R7)
    for (int ch = 0; ch < NCH; ch++) begin
      for (int k = 0; k < 7; k++) begin
        int c, srcW, dstW, first, svc, mis, moved;
        c = (k * k * 4) % 68;
        srcW = ch * 64 + k * 8;
        dstW = 600;
        stallMode = (ch >= 2);
        for (int j = 0; j < 18; j++) poke(dstW + j, 32'hDEADBEEF);
        wr(ch*4 + 0, 32'(srcW * 4));
        wr(ch*4 + 1, 32'(dstW * 4));
        wr(ch*4 + 2, 32'(c));
        wr(ch*4 + 3, 32'h8000_0000);
        rd(ch*4 + 3, v); chk("R5", "valid start accepted", v, 32'h8000_0000);
        first = ((ch - expPtr + NCH) % NCH) + 1;
        svc = (c + BURST - 1) / BURST + 1;
        if (c > 0) begin
          moved = (c < BURST) ? c : BURST;
          ticks(first - 1);
          rd(ch*4 + 2, v); chk("R1", "count untouched before own slot", v, 32'(c));
          ticks(1);
          rd(ch*4 + 2, v); chk("R2", "count after first visit", v, 32'(c - moved));
          rd(ch*4 + 0, v); chk("R2", "src after first visit", v, 32'(srcW*4 + moved));
          rd(DONE_R, v);   chk("R3", "no completion mid transfer", v, 32'h0);
        end else begin
          ticks(first);
        end
        ticks((svc - 1) * NCH);
        rd(DONE_R, v);   chk("R3", "completion flag", v, 32'(1 << ch));
        chk("R7", "irq on completion", {31'b0, irq}, 32'h1);
        rd(ch*4 + 3, v); chk("R3", "run cleared", v, 32'h0);
        rd(ch*4 + 2, v); chk("R2", "count drained", v, 32'h0);
        rd(ch*4 + 1, v); chk("R2", "dst advanced", v, 32'(dstW*4 + c));
        mis = 0;
        for (int j = 0; j < c/4; j++) if (mem[dstW + j] !== pat(srcW + j)) mis++;
        chk("R2", "copied words mismatching", 32'(mis), 32'h0);
        chk("R2", "word past end untouched", mem[dstW + c/4], 32'hDEADBEEF);
        wr(DONE_R, 32'(1 << ch));
        rd(DONE_R, v); chk("R7", "completion cleared", v, 32'h0);
        chk("R7", "irq low after clear", {31'b0, irq}, 32'h0);
      end
    end
    stallMode = 1'b0;

    // Fault injection (R4 R7)
    for (int j = 0; j < 8; j++) poke(700 + j, 32'hDEADBEEF);
    wr(FAIL_R + 1, 32'd5);
    wr(FAIL_R + 3, 32'd2);
    wr(3*4 + 0, 32'h40);
    wr(3*4 + 1, 32'(700 * 4));
    wr(3*4 + 2, 32'd48);
    wr(3*4 + 3, 32'h8000_0000);
    ticks(((3 - expPtr + NCH) % NCH) + 1);
    rd(FAIL_R + 3, v); chk("R4", "fault counter decremented", v, 32'd1);
    rd(3*4 + 2, v);    chk("R4", "burst still moved before expiry", v, 32'd32);
    rd(FAIL_R + 1, v); chk("R4", "idle channel counter untouched", v, 32'd5);
    ticks(NCH);
    rd(ERR_R, v);      chk("R4", "error flag", v, 32'h8);
    rd(DONE_R, v);     chk("R4", "no completion on fault", v, 32'h0);
    rd(3*4 + 3, v);    chk("R4", "run cleared on fault", v, 32'h0);
    rd(3*4 + 2, v);    chk("R4", "count unchanged on fault", v, 32'd32);
    rd(FAIL_R + 3, v); chk("R4", "counter at zero", v, 32'd0);
    chk("R4", "no data moved on fault", mem[704], 32'hDEADBEEF);
    chk("R4", "irq on fault", {31'b0, irq}, 32'h1);
    wr(DONE_R, 32'hF);
    chk("R7", "other flag clear keeps irq", {31'b0, irq}, 32'h1);
    wr(ERR_R, 32'h0);
    rd(ERR_R, v);      chk("R7", "writing zero keeps flag", v, 32'h8);
    wr(ERR_R, 32'h8);
    rd(ERR_R, v);      chk("R7", "error flag cleared", v, 32'h0);
    chk("R7", "irq low", {31'b0, irq}, 32'h0);
    wr(FAIL_R + 1, 32'd0);

    // Start validation, frozen registers, stop (R5 R9 R6)
    wr(1*4 + 2, 32'd6);      wr(1*4 + 3, 32'h8000_0000);
    rd(1*4 + 3, v); chk("R5", "unaligned count rejected", v, 32'h0);
    wr(1*4 + 2, 32'h2000);   wr(1*4 + 3, 32'h8000_0000);
    rd(1*4 + 3, v); chk("R5", "oversize count rejected", v, 32'h0);
    wr(1*4 + 2, 32'h1FFC);   wr(1*4 + 0, 32'h100); wr(1*4 + 3, 32'h8000_0000);
    rd(1*4 + 3, v); chk("R5", "largest aligned count accepted", v, 32'h8000_0000);
    wr(1*4 + 0, 32'h44);
    rd(1*4 + 0, v); chk("R9", "src write ignored while running", v, 32'h100);
    wr(1*4 + 2, 32'd8);
    rd(1*4 + 2, v); chk("R9", "count write ignored while running", v, 32'h1FFC);
    wr(1*4 + 3, 32'h0);
    rd(1*4 + 3, v); chk("R6", "stop clears run", v, 32'h0);
    rd(1*4 + 2, v); chk("R6", "stop keeps count", v, 32'h1FFC);
    rd(DONE_R, v);  chk("R6", "stop raises no completion", v, 32'h0);
    chk("R6", "irq low after stop", {31'b0, irq}, 32'h0);

    // Ticks ignored during a burst (R8)
    while (expPtr != 0) tickOnce();
    wr(0*4 + 0, 32'h0);   wr(0*4 + 1, 32'(800*4)); wr(0*4 + 2, 32'd16);
    wr(1*4 + 0, 32'h80);  wr(1*4 + 1, 32'(820*4)); wr(1*4 + 2, 32'd4);
    wr(0*4 + 3, 32'h8000_0000);
    wr(1*4 + 3, 32'h8000_0000);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R8", "busy during burst", {31'b0, busy}, 32'h1);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    while (busy) @(negedge clk);
    expPtr = 1;
    rd(1*4 + 2, v); chk("R8", "spare tick did not service next channel", v, 32'd4);
    tickOnce();
    rd(1*4 + 2, v); chk("R8", "next tick serviced channel 1", v, 32'd0);
    chk("R2", "channel 1 word copied", mem[820], pat(32));
    ticks(NCH);
    rd(DONE_R, v);  chk("R3", "both channels completed", v, 32'h3);
    wr(DONE_R, 32'h3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule